// File: doc/BRIEF.md
# Segmented response reader for a system-management block-read channel

This block is the read side of an SMBus-style management target. A response message of up to 255 bytes is loaded through a length-plus-byte-stream port. The host then fetches it in block-read chunks of at most 32 data bytes. A read-start command picks one block. The block is staged into a 33-entry output buffer, which holds a length byte followed by the data. Each receive-byte request then returns the next buffer entry.

Short responses go out as a single block. Long responses are split: the first block carries a two-byte start marker and 30 message bytes, and each later block carries a sequence byte and up to 31 message bytes. The last block is tagged with an end marker. A retry command fetches any block again by number. A loaded response is accepted only if its tag matches the tag the block expects next.

Top module: `ssif_rsp_segmenter`

## Requirements
- R1: Command codes act on a block index. Code 0x03 sets the index to 0. Code 0x09 adds one to the index (modulo 256). Code 0x0A with an argument sets the index to the argument. Code 0x0A without an argument is an error and leaves the index unchanged. Any other code is ignored and raises no error. All codes are ignored while a copy is in progress or in a cycle where a response load is accepted.
- R2: A command that tries to stage a block while the stored response length is 0 is an error.
- R3: A response of 1 to 32 bytes is staged as one block: buffer entry 0 is the length, and entries 1 onward are the whole message. Any block index other than 0 is an error.
- R4: For a response longer than 32 bytes, block 0 is staged as follows: entry 0 is 32, entry 1 is 0x00, entry 2 is 0x01, and entries 3 to 32 are message bytes 0 to 29.
- R5: Block n (n ≥ 1) of a long response starts at message offset 30 + 31·(n−1). If that offset is at or past the message length, staging is an error.
- R6: A block n ≥ 1 with more than 31 bytes remaining carries 31 bytes, and entry 1 is n−1. Otherwise it carries the remaining bytes, and entry 1 is 0xFF. In both cases entry 0 is the data count plus one, and the data starts at entry 2.
- R7: Each served receive-byte request returns the next buffer entry. Once all 33 entries have been read, every further request returns 0xFF. Entries that a staging did not write keep their earlier contents.
- R8: An accepted load sets the block index to 0, sets the read pointer to 0, and clears the ready flag.
- R9: A load is accepted only when its tag equals the expected tag, which starts at 0 after reset. Each accepted load increments the expected tag modulo 256. A load with a mismatched tag, and the bytes that follow it, leave the stored response unchanged.
- R10: A successful staging resets the read pointer. It copies one message byte per clock and raises `stage_ready_o` when the copy is done. A receive-byte request while not ready gives no `rd_valid_o` and does not move the read pointer. A served request gives `rd_valid_o` with the byte in the cycle after the request.
- R11: A load longer than 255 bytes is cut to 255 bytes, and message byte 2 is stored as 0xCA.
- R12: `cmd_err_o` is a one-cycle pulse in the cycle after a failing command. A failing command leaves the buffer, the ready flag and the read pointer as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code |
| cmd_has_arg_i | input | 1 | Command carries an argument byte |
| cmd_arg_i | input | 8 | Argument byte (block number for retry) |
| rsp_start_i | input | 1 | Start of a response load |
| rsp_len_i | input | LEN_IN_W | Response length offered at load start |
| rsp_tag_i | input | 8 | Sequence tag of the offered response |
| rsp_byte_valid_i | input | 1 | Response byte strobe |
| rsp_byte_i | input | 8 | Response byte, in message order |
| rd_req_i | input | 1 | Receive-byte request |
| rd_byte_o | output | 8 | Returned byte |
| rd_valid_o | output | 1 | `rd_byte_o` is valid |
| stage_ready_o | output | 1 | Output buffer staged and readable |
| cmd_err_o | output | 1 | Command failed |

## Verification
The hardest case to reach is the final block of a response that was truncated. The stimulus loads 300 bytes and then uses a retry to jump straight to block 8, which ends exactly at byte 255. A retry to block 9 then checks the offset-past-end error on the same message. Stale buffer contents are also hard to see from the ports. A short final block leaves old bytes in the tail of the buffer, and the stimulus reads every one of the 33 entries after each staging, plus one read past the end. The bench keeps a model of the buffer that includes those leftovers.

// File: rtl/ssif_seg_pkg.sv
package ssif_seg_pkg;
  localparam logic [7:0] CMD_RD_FIRST = 8'h03;
  localparam logic [7:0] CMD_RD_NEXT  = 8'h09;
  localparam logic [7:0] CMD_RD_RETRY = 8'h0A;
  localparam logic [7:0] CC_TRUNC     = 8'hCA;
  localparam logic [7:0] END_MARK     = 8'hFF;
  localparam logic [7:0] START_MARK0  = 8'h00;
  localparam logic [7:0] START_MARK1  = 8'h01;
endpackage

// File: rtl/ssif_msg_store.sv
module ssif_msg_store
  import ssif_seg_pkg::*;
#(
  parameter int MSG_MAX  = 255,
  parameter int LEN_IN_W = 9,
  parameter int AW       = $clog2(MSG_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [LEN_IN_W-1:0] len_i,
  input  logic [7:0]          tag_i,
  input  logic                byte_valid_i,
  input  logic [7:0]          byte_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [7:0]          rd_data_o,
  output logic [AW-1:0]       msg_len_o,
  output logic [7:0]          exp_tag_o,
  output logic                load_o
);
  logic [7:0]    mem [0:MSG_MAX-1];
  logic [AW-1:0] wptr;
  logic          loading, trunc;
  logic          wr_en;
  logic [7:0]    wr_dat;

  assign load_o    = start_i && (tag_i == exp_tag_o);
  assign wr_en     = !start_i && byte_valid_i && loading && (int'(wptr) < MSG_MAX);
  // third message byte becomes the truncation completion code
  assign wr_dat    = (trunc && wptr == AW'(2)) ? CC_TRUNC : byte_i;
  assign rd_data_o = (int'(rd_addr_i) < MSG_MAX) ? mem[rd_addr_i] : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_tag_o <= '0;
      msg_len_o <= '0;
      wptr      <= '0;
      loading   <= 1'b0;
      trunc     <= 1'b0;
    end else if (load_o) begin
      exp_tag_o <= exp_tag_o + 8'd1;
      trunc     <= (int'(len_i) > MSG_MAX);
      msg_len_o <= (int'(len_i) > MSG_MAX) ? AW'(MSG_MAX) : AW'(len_i);
      wptr      <= '0;
      loading   <= 1'b1;
    end else if (start_i) begin
      loading   <= 1'b0;
    end else if (wr_en) begin
      wptr      <= wptr + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wptr] <= wr_dat;
  end
endmodule

// File: rtl/ssif_blk_plan.sv
module ssif_blk_plan
  import ssif_seg_pkg::*;
#(
  parameter int CHUNK = 32,
  parameter int AW    = 8,
  parameter int OB_AW = $clog2(CHUNK + 2)
) (
  input  logic [AW-1:0]    msg_len_i,
  input  logic [7:0]       blk_i,
  output logic             ok_o,
  output logic [7:0]       hdr0_o,
  output logic [7:0]       hdr1_o,
  output logic [7:0]       hdr2_o,
  output logic [1:0]       hdr_n_o,
  output logic [AW-1:0]    src_o,
  output logic [OB_AW-1:0] dst_o,
  output logic [OB_AW-1:0] cnt_o
);
  localparam int FIRST = CHUNK - 2;
  localparam int MID   = CHUNK - 1;

  logic [15:0] pos, rem;

  always_comb begin
    pos     = 16'(FIRST) + 16'(blk_i - 8'd1) * 16'(MID);
    rem     = 16'(msg_len_i) - pos;
    ok_o    = 1'b0;
    hdr0_o  = '0;
    hdr1_o  = '0;
    hdr2_o  = '0;
    hdr_n_o = 2'd1;
    src_o   = '0;
    dst_o   = OB_AW'(1);
    cnt_o   = '0;
    if (msg_len_i == '0) begin
      ok_o = 1'b0;
    end else if (int'(msg_len_i) <= CHUNK) begin
      ok_o   = (blk_i == 8'd0);
      hdr0_o = 8'(msg_len_i);
      cnt_o  = OB_AW'(msg_len_i);
    end else if (blk_i == 8'd0) begin
      ok_o    = 1'b1;
      hdr0_o  = 8'(CHUNK);
      hdr1_o  = START_MARK0;
      hdr2_o  = START_MARK1;
      hdr_n_o = 2'd3;
      dst_o   = OB_AW'(3);
      cnt_o   = OB_AW'(FIRST);
    end else if (pos < 16'(msg_len_i)) begin
      ok_o    = 1'b1;
      hdr_n_o = 2'd2;
      dst_o   = OB_AW'(2);
      src_o   = AW'(pos);
      if (rem > 16'(MID)) begin
        cnt_o  = OB_AW'(MID);
        hdr1_o = blk_i - 8'd1;
      end else begin
        cnt_o  = OB_AW'(rem);
        hdr1_o = END_MARK;
      end
      hdr0_o = 8'(cnt_o) + 8'd1;
    end
  end
endmodule

// File: rtl/ssif_out_buf.sv
module ssif_out_buf
  import ssif_seg_pkg::*;
#(
  parameter int CHUNK = 32,
  parameter int AW    = 8,
  parameter int OB_AW = $clog2(CHUNK + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic [7:0]       hdr0_i,
  input  logic [7:0]       hdr1_i,
  input  logic [7:0]       hdr2_i,
  input  logic [1:0]       hdr_n_i,
  input  logic [AW-1:0]    src_i,
  input  logic [OB_AW-1:0] dst_i,
  input  logic [OB_AW-1:0] cnt_i,
  input  logic [7:0]       mem_data_i,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             rd_req_i,
  output logic [7:0]       rd_byte_o,
  output logic             rd_valid_o,
  output logic             busy_o,
  output logic             ready_o
);
  localparam int OBUF_N = CHUNK + 1;

  logic [7:0]       obuf [0:OBUF_N-1];
  logic [OB_AW-1:0] idx, dst_r, cnt_r, rptr;
  logic [AW-1:0]    src_r;

  assign mem_addr_o = src_r + AW'(idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      ready_o    <= 1'b0;
      idx        <= '0;
      dst_r      <= '0;
      cnt_r      <= '0;
      src_r      <= '0;
      rptr       <= '0;
      rd_valid_o <= 1'b0;
      rd_byte_o  <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      if (clear_i) begin
        busy_o  <= 1'b0;
        ready_o <= 1'b0;
        rptr    <= '0;
      end else if (start_i) begin
        busy_o  <= (cnt_i != '0);
        ready_o <= (cnt_i == '0);
        idx     <= '0;
        dst_r   <= dst_i;
        cnt_r   <= cnt_i;
        src_r   <= src_i;
        rptr    <= '0;
      end else if (busy_o) begin
        idx <= idx + 1'b1;
        if (idx == cnt_r - 1'b1) begin
          busy_o  <= 1'b0;
          ready_o <= 1'b1;
        end
      end else if (rd_req_i && ready_o) begin
        rd_valid_o <= 1'b1;
        if (int'(rptr) < OBUF_N) begin
          rd_byte_o <= obuf[rptr];
          rptr      <= rptr + 1'b1;
        end else begin
          rd_byte_o <= END_MARK;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < OBUF_N; i++) obuf[i] <= '0;
    end else if (!clear_i && start_i) begin
      obuf[0] <= hdr0_i;
      if (hdr_n_i >= 2'd2) obuf[1] <= hdr1_i;
      if (hdr_n_i == 2'd3) obuf[2] <= hdr2_i;
    end else if (!clear_i && busy_o) begin
      obuf[dst_r + idx] <= mem_data_i;
    end
  end
endmodule

// File: rtl/ssif_rsp_segmenter.sv
module ssif_rsp_segmenter
  import ssif_seg_pkg::*;
#(
  parameter int MSG_MAX  = 255,
  parameter int CHUNK    = 32,
  parameter int LEN_IN_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [7:0]          cmd_code_i,
  input  logic                cmd_has_arg_i,
  input  logic [7:0]          cmd_arg_i,
  input  logic                rsp_start_i,
  input  logic [LEN_IN_W-1:0] rsp_len_i,
  input  logic [7:0]          rsp_tag_i,
  input  logic                rsp_byte_valid_i,
  input  logic [7:0]          rsp_byte_i,
  input  logic                rd_req_i,
  output logic [7:0]          rd_byte_o,
  output logic                rd_valid_o,
  output logic                stage_ready_o,
  output logic                cmd_err_o
);
  localparam int AW    = $clog2(MSG_MAX + 1);
  localparam int OB_AW = $clog2(CHUNK + 2);

  logic [AW-1:0]    msg_len, mem_addr;
  logic [7:0]       mem_data, exp_tag;
  logic             load_acc, copy_busy;
  logic [7:0]       blk_q, blk_nx;
  logic             cmd_take, known, noarg_err, stage_go, err_nx;
  logic             p_ok;
  logic [7:0]       p_h0, p_h1, p_h2;
  logic [1:0]       p_hn;
  logic [AW-1:0]    p_src;
  logic [OB_AW-1:0] p_dst, p_cnt;

  ssif_msg_store #(.MSG_MAX(MSG_MAX), .LEN_IN_W(LEN_IN_W), .AW(AW)) u_store (
    .clk_i, .rst_ni,
    .start_i(rsp_start_i), .len_i(rsp_len_i), .tag_i(rsp_tag_i),
    .byte_valid_i(rsp_byte_valid_i), .byte_i(rsp_byte_i),
    .rd_addr_i(mem_addr), .rd_data_o(mem_data),
    .msg_len_o(msg_len), .exp_tag_o(exp_tag), .load_o(load_acc)
  );

  always_comb begin
    cmd_take  = cmd_valid_i && !copy_busy && !load_acc;
    noarg_err = (cmd_code_i == CMD_RD_RETRY) && !cmd_has_arg_i;
    known     = 1'b1;
    unique case (cmd_code_i)
      CMD_RD_FIRST: blk_nx = 8'd0;
      CMD_RD_NEXT:  blk_nx = blk_q + 8'd1;
      CMD_RD_RETRY: begin blk_nx = cmd_arg_i; known = cmd_has_arg_i; end
      default:      begin blk_nx = blk_q; known = 1'b0; end
    endcase
  end

  ssif_blk_plan #(.CHUNK(CHUNK), .AW(AW), .OB_AW(OB_AW)) u_plan (
    .msg_len_i(msg_len), .blk_i(blk_nx), .ok_o(p_ok),
    .hdr0_o(p_h0), .hdr1_o(p_h1), .hdr2_o(p_h2), .hdr_n_o(p_hn),
    .src_o(p_src), .dst_o(p_dst), .cnt_o(p_cnt)
  );

  assign stage_go = cmd_take && known && p_ok;
  assign err_nx   = cmd_take && (noarg_err || (known && !p_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q     <= '0;
      cmd_err_o <= 1'b0;
    end else begin
      cmd_err_o <= err_nx;
      if (load_acc)              blk_q <= '0;
      else if (cmd_take && known) blk_q <= blk_nx;
    end
  end

  ssif_out_buf #(.CHUNK(CHUNK), .AW(AW), .OB_AW(OB_AW)) u_obuf (
    .clk_i, .rst_ni,
    .clear_i(load_acc), .start_i(stage_go),
    .hdr0_i(p_h0), .hdr1_i(p_h1), .hdr2_i(p_h2), .hdr_n_i(p_hn),
    .src_i(p_src), .dst_i(p_dst), .cnt_i(p_cnt),
    .mem_data_i(mem_data), .mem_addr_o(mem_addr),
    .rd_req_i, .rd_byte_o, .rd_valid_o,
    .busy_o(copy_busy), .ready_o(stage_ready_o)
  );
endmodule

// File: rtl/ssif_seg_chk.sv
module ssif_seg_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [7:0]    cmd_code_i,
  input logic          rd_req_i,
  input logic          rd_valid_o,
  input logic          stage_ready_o,
  input logic          cmd_err_o,
  input logic          busy_i,
  input logic          load_i,
  input logic [7:0]    exp_tag_i,
  input logic [AW-1:0] msg_len_i
);
  // R12
  err_after_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> $past(cmd_valid_i));
  // R10
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i && stage_ready_o));
  // R10
  ready_after_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_ready_o) |-> $past(busy_i));
  // R8
  load_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!stage_ready_o && !busy_i));
  // R9
  tag_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (exp_tag_i == 8'($past(exp_tag_i) + 8'd1)));
  // R2
  empty_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_code_i == 8'h03 && msg_len_i == '0 && !busy_i && !load_i)
      |=> cmd_err_o);
endmodule

bind ssif_rsp_segmenter ssif_seg_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_code_i(cmd_code_i), .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o),
  .stage_ready_o(stage_ready_o), .cmd_err_o(cmd_err_o), .busy_i(copy_busy),
  .load_i(load_acc), .exp_tag_i(exp_tag), .msg_len_i(msg_len)
);

// File: tb/ssif_rsp_segmenter_bench.sv
module ssif_rsp_segmenter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 0, cmd_has_arg = 0;
  logic [7:0] cmd_code = 0, cmd_arg = 0;
  logic       rsp_start = 0, rsp_bv = 0;
  logic [8:0] rsp_len = 0;
  logic [7:0] rsp_tag = 0, rsp_byte = 0;
  logic       rd_req = 0;
  logic [7:0] rd_byte;
  logic       rd_valid, stage_ready, cmd_err;

  always #4 clk = ~clk;

  ssif_rsp_segmenter u_ssif_rsp_segmenter (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .cmd_has_arg_i(cmd_has_arg),
    .cmd_arg_i(cmd_arg), .rsp_start_i(rsp_start), .rsp_len_i(rsp_len),
    .rsp_tag_i(rsp_tag), .rsp_byte_valid_i(rsp_bv), .rsp_byte_i(rsp_byte),
    .rd_req_i(rd_req), .rd_byte_o(rd_byte), .rd_valid_o(rd_valid),
    .stage_ready_o(stage_ready), .cmd_err_o(cmd_err)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] msg [0:254];
  int mlen = 0, mtag = 0, mblk = 0;
  logic [7:0] mobuf [0:32];
  logic [7:0] exp_q [$];
  string      req_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected byte", int'(rd_byte), -1);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(rd_byte == e, r, int'(rd_byte), int'(e));
      end
    end
  end

  task automatic load(input int n, input int tag, input int seed);
    @(negedge clk);
    rsp_start = 1; rsp_len = 9'(n); rsp_tag = 8'(tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rsp_start = 0; rsp_bv = 1; rsp_byte = 8'(seed + i * 7);
    end
    @(negedge clk);
    rsp_start = 0; rsp_bv = 0;
    if (tag == mtag) begin
      mtag = (mtag + 1) % 256;
      mlen = (n > 255) ? 255 : n;
      for (int i = 0; i < mlen; i++) msg[i] = 8'(seed + i * 7);
      if (n > 255) msg[2] = 8'hCA;
      mblk = 0;
    end
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 34; i++) begin
      @(negedge clk);
      rd_req = 1;
      exp_q.push_back(i < 33 ? mobuf[i] : 8'hFF);
      req_q.push_back(i < 33 ? req : "R7");
    end
    @(negedge clk); rd_req = 0;
    @(negedge clk); @(negedge clk);
    check(exp_q.size() == 0, "R7 all bytes returned", exp_q.size(), 0);
  endtask

  task automatic do_cmd(input int code, input bit has, input int arg, input string req);
    automatic int nb = mblk;
    automatic bit known = (code == 3) || (code == 9) || (code == 10 && has);
    automatic bit ok = 0, exp_err;
    automatic logic [7:0] t [0:32];
    for (int i = 0; i < 33; i++) t[i] = mobuf[i];
    if (code == 3) nb = 0;
    else if (code == 9) nb = (mblk + 1) % 256;
    else if (code == 10 && has) nb = arg;
    if (known && mlen != 0) begin
      if (mlen <= 32) begin
        ok = (nb == 0);
        t[0] = 8'(mlen);
        for (int i = 0; i < mlen; i++) t[1 + i] = msg[i];
      end else if (nb == 0) begin
        ok = 1; t[0] = 32; t[1] = 0; t[2] = 1;
        for (int i = 0; i < 30; i++) t[3 + i] = msg[i];
      end else begin
        automatic int pos = 30 + (nb - 1) * 31;
        if (pos < mlen) begin
          automatic int rem = mlen - pos;
          automatic int c = (rem > 31) ? 31 : rem;
          ok = 1;
          t[0] = 8'(c + 1);
          t[1] = (rem > 31) ? 8'(nb - 1) : 8'hFF;
          for (int i = 0; i < c; i++) t[2 + i] = msg[pos + i];
        end
      end
    end
    exp_err = (code == 10 && !has) || (known && !ok);
    if (known) mblk = nb;
    @(negedge clk);
    cmd_valid = 1; cmd_code = 8'(code); cmd_has_arg = has; cmd_arg = 8'(arg);
    @(negedge clk);
    cmd_valid = 0;
    check(cmd_err == exp_err, {req, " R12 error flag"}, int'(cmd_err), int'(exp_err));
    @(negedge clk);
    check(cmd_err == 1'b0, "R12 error is one pulse", int'(cmd_err), 0);
    if (ok) begin
      for (int i = 0; i < 100 && !stage_ready; i++) @(negedge clk);
      check(stage_ready == 1'b1, "R10 ready after copy", int'(stage_ready), 1);
      for (int i = 0; i < 33; i++) mobuf[i] = t[i];
      read_all(req);
    end
  endtask

  initial begin
    for (int i = 0; i < 33; i++) mobuf[i] = 0;
    repeat (3) @(negedge clk);
    check(rd_valid == 0 && cmd_err == 0 && stage_ready == 0, "R10 reset state",
          {rd_valid, cmd_err, stage_ready}, 0);
    rst_n = 1;
    // R2: nothing loaded yet
    do_cmd(3, 0, 0, "R2");
    // R3 short message, then non-zero block
    load(5, 0, 8'h10);
    check(stage_ready == 0, "R8 ready cleared by load", int'(stage_ready), 0);
    // R10: reads held off before staging
    @(negedge clk); rd_req = 1;
    @(negedge clk); check(rd_valid == 0, "R10 held off", int'(rd_valid), 0);
    @(negedge clk); rd_req = 0; check(rd_valid == 0, "R10 held off", int'(rd_valid), 0);
    do_cmd(3, 0, 0, "R3");
    do_cmd(9, 0, 0, "R3");
    do_cmd(5, 0, 0, "R1 unknown code");
    // R9 tag mismatch ignored
    load(10, 7, 8'h55);
    do_cmd(3, 0, 0, "R9");
    // R4 R5 R6 on 100 bytes
    load(100, 1, 8'h20);
    do_cmd(3, 0, 0, "R4");
    do_cmd(9, 0, 0, "R6");
    do_cmd(9, 0, 0, "R6");
    do_cmd(9, 0, 0, "R6 final");
    do_cmd(9, 0, 0, "R5");
    do_cmd(10, 1, 1, "R1 retry");
    do_cmd(10, 0, 0, "R1 retry no arg");
    do_cmd(9, 0, 0, "R1 next after retry");
    // R8: load resets block index
    load(100, 2, 8'h77);
    do_cmd(9, 0, 0, "R8");
    // R11 truncation
    load(300, 3, 8'h01);
    do_cmd(3, 0, 0, "R11");
    do_cmd(10, 1, 8, "R11 last block");
    do_cmd(10, 1, 9, "R5");
    // boundaries 32 and 33
    load(32, 4, 8'h90);
    do_cmd(3, 0, 0, "R3 32 bytes");
    load(33, 5, 8'hA0);
    do_cmd(10, 1, 1, "R6 33 bytes");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule